// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block sits between a core and a slower word-wide memory port and keeps recently used blocks of consecutive words in a small set-associative store. The core issues one whole-word read or write at a time and holds its request until a one-cycle completion pulse. Hits complete from the local store. Misses fetch a whole block from memory, after first writing back a modified victim when that is needed.

Two runtime settings shape the behaviour. One picks the victim policy when every way of a set is occupied: pseudo-random, least recently used, or least frequently used. The other picks write-back or write-through. Two counters record hits and misses. A single invalidate input empties the whole store in one cycle.

Top module: `set_assoc_cache`

## Requirements
- R1: A word address splits into a word offset (lowest log2(BLOCK_WORDS) bits), a set index (the next log2(SETS) bits) and a tag (all remaining bits); a fill or a write-back moves the BLOCK_WORDS words of one block in ascending offset order, starting at offset 0.
- R2: A read whose set holds a valid line with a matching tag returns that line's word with no memory transfer; every access ends with core_done high for exactly one cycle.
- R3: On a miss, the lowest-numbered invalid way of the set is filled before any replacement policy is consulted.
- R4: With repl_mode = 0 (random) and all ways valid, a pseudo-random sequence picks the victim way, and the missed block is resident afterwards.
- R5: With repl_mode = 1 (LRU) and all ways valid, the victim is the way whose last access is oldest.
- R6: With repl_mode = 2 (LFU) and all ways valid, the victim is the way with the fewest accesses since its fill (lowest way on a tie), even when that way was touched most recently.
- R7: With wb_mode = 0 (write-through), every core write issues exactly one memory write of that word; a write hit also updates the stored word; a write miss does not allocate a line.
- R8: With wb_mode = 1 (write-back), a write hit causes no memory transfer; a modified victim is written back as a whole block before the fill that replaces it.
- R9: Each access increments exactly one of hit_cnt or miss_cnt, by one.
- R10: A high inv_all while idle invalidates every line in one cycle, discards unwritten modified data, leaves the counters unchanged, and takes priority over a request presented in the same cycle.
- R11: mem_req, mem_we, mem_addr and mem_wdata stay stable while mem_req is high and mem_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| repl_mode | input | 2 | Victim policy: 0 random, 1 LRU, 2 LFU |
| wb_mode | input | 1 | 1 write-back, 0 write-through |
| inv_all | input | 1 | Whole-store invalidate, sampled while idle |
| core_req | input | 1 | Core access request, held until core_done |
| core_we | input | 1 | 1 write, 0 read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Write word |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Read word, valid with core_done |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ready | input | 1 | Memory accepts or returns the beat |
| mem_rdata | input | DATA_W | Memory read word, valid with mem_ready |
| hit_cnt | output | CNT_W | Hit count |
| miss_cnt | output | CNT_W | Miss count |

## Verification
Two functions can fall in one cycle: a whole-store invalidate and a core request that would otherwise hit. The bench first makes a block resident and confirms that it hits. It then raises inv_all in the very cycle its request arrives. The access is judged by the counter deltas and the memory read beats: one miss, no hit, and a full block fetched. The returned word must also match the bench's memory model.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the set-associative cache controller.
package cache_pkg;
    typedef enum logic [1:0] {
        REPL_RAND = 2'd0,
        REPL_LRU  = 2'd1,
        REPL_LFU  = 2'd2
    } repl_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_RESP
    } cstate_e;
endpackage

// File: rtl/cache_lfsr.sv
`timescale 1ns/1ps
// Free-running 8-bit maximal-length shift register used for random victim choice.
// Assumes: W = 8 (taps fixed for that length); runs every cycle.
module cache_lfsr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    logic fb;

    // Feedback from taps 8,6,5,4.
    always_comb fb = q[W-1] ^ q[W-3] ^ q[W-4] ^ q[W-5];

    // Shift each cycle from a nonzero seed.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= W'(1);
        else        q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/cache_match.sv
`timescale 1ns/1ps
// Parallel tag compare across the ways of one set.
// Assumes: at most one valid way carries a given tag.
module cache_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag_in,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = valid[w] && (tags[w] == tag_in);
    end

    // Encode the matching way.
    always_comb begin
        hit     = |eq;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (eq[w]) hit_way = WAY_W'(w);
    end
endmodule

// File: rtl/cache_victim.sv
`timescale 1ns/1ps
// Victim way selection: lowest invalid way first, else by policy.
// Assumes: ages hold last-access stamps (LRU) or access counts (LFU).
module cache_victim #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 16,
    parameter int RND_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    input  logic [RND_W-1:0]           rnd,
    input  cache_pkg::repl_e           mode,
    output logic [WAY_W-1:0]           way
);
    logic [RND_W-1:0] rmod;
    logic [WAY_W-1:0] free_way, old_way;
    logic [AGE_W-1:0] best_age;
    logic             found;

    assign rmod = rnd % RND_W'(WAYS);

    // Find the lowest invalid way and the lowest-age way.
    always_comb begin
        found    = 1'b0;
        free_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !found) begin
                found    = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        old_way  = '0;
        best_age = ages[0];
        for (int w = 1; w < WAYS; w++) begin
            if (ages[w] < best_age) begin
                best_age = ages[w];
                old_way  = WAY_W'(w);
            end
        end
    end

    // Pick the final victim.
    always_comb begin
        if (found)                              way = free_way;
        else if (mode == cache_pkg::REPL_RAND)  way = rmod[WAY_W-1:0];
        else                                    way = old_way;
    end
endmodule

// File: rtl/set_assoc_cache.sv
`timescale 1ns/1ps
// Word-addressed set-associative cache with selectable victim and write policy.
// Assumes: SETS, BLOCK_WORDS, WAYS are powers of two and at least 2; the core
// holds its request until core_done; inv_all is honoured only when idle.
module set_assoc_cache import cache_pkg::*; #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SETS        = 4,
    parameter int BLOCK_WORDS = 4,
    parameter int WAYS        = 2,
    parameter int AGE_W       = 16,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        repl_mode,
    input  logic              wb_mode,
    input  logic              inv_all,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    localparam int OFF_W  = $clog2(BLOCK_WORDS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int RND_W  = 8;

    cstate_e st;
    repl_e   mode;
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0][AGE_W-1:0] age_q   [SETS];
    logic [DATA_W-1:0]          data_q  [SETS][WAYS][BLOCK_WORDS];

    logic [SET_W-1:0]  set_r;
    logic [TAG_W-1:0]  tag_r;
    logic [WAY_W-1:0]  way_r;
    logic [OFF_W-1:0]  beat_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] wdata_r, rdata_r;
    logic [AGE_W-1:0]  stamp_q, cur_age;
    logic              replay_r;

    logic [OFF_W-1:0]  in_off;
    logic [SET_W-1:0]  in_set;
    logic [TAG_W-1:0]  in_tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, vic_way;
    logic [RND_W-1:0]  rnd;
    logic              last_beat, go;

    assign mode      = repl_e'(repl_mode);
    assign in_off    = core_addr[OFF_W-1:0];
    assign in_set    = core_addr[OFF_W+SET_W-1:OFF_W];
    assign in_tag    = core_addr[ADDR_W-1:OFF_W+SET_W];
    assign cur_age   = age_q[in_set][hit_way];
    assign last_beat = (beat_r == OFF_W'(BLOCK_WORDS-1));
    assign go        = (st == ST_IDLE) && core_req && !inv_all;
    assign core_done = (st == ST_RESP);
    assign core_rdata = rdata_r;

    cache_lfsr #(.W(RND_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .q(rnd));

    cache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid(valid_q[in_set]), .tags(tag_q[in_set]), .tag_in(in_tag),
        .hit(hit), .hit_way(hit_way)
    );

    cache_victim #(.WAYS(WAYS), .AGE_W(AGE_W), .RND_W(RND_W)) u_victim (
        .valid(valid_q[in_set]), .ages(age_q[in_set]), .rnd(rnd),
        .mode(mode), .way(vic_way)
    );

    // Drive the memory port from the transfer state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_r;
        mem_wdata = wdata_r;
        case (st)
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[set_r][way_r], set_r, beat_r};
                mem_wdata = data_q[set_r][way_r][beat_r];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {tag_r, set_r, beat_r};
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Store word data from core writes and block fills.
    always_ff @(posedge clk) begin
        if (go && hit && core_we)
            data_q[in_set][hit_way][in_off] <= core_wdata;
        if (st == ST_FILL && mem_ready)
            data_q[set_r][way_r][beat_r] <= mem_rdata;
    end

    // Control sequence, line state, policy metrics and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            set_r    <= '0;
            tag_r    <= '0;
            way_r    <= '0;
            beat_r   <= '0;
            addr_r   <= '0;
            wdata_r  <= '0;
            rdata_r  <= '0;
            stamp_q  <= '0;
            replay_r <= 1'b0;
            hit_cnt  <= '0;
            miss_cnt <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                tag_q[s]   <= '0;
                age_q[s]   <= '0;
            end
        end else begin
            case (st)
                ST_IDLE: begin
                    if (inv_all) begin
                        replay_r <= 1'b0;
                        for (int s = 0; s < SETS; s++) begin
                            valid_q[s] <= '0;
                            dirty_q[s] <= '0;
                            age_q[s]   <= '0;
                        end
                    end else if (core_req) begin
                        set_r   <= in_set;
                        tag_r   <= in_tag;
                        addr_r  <= core_addr;
                        wdata_r <= core_wdata;
                        if (hit) begin
                            replay_r <= 1'b0;
                            if (!replay_r) hit_cnt <= hit_cnt + 1'b1;
                            if (mode == REPL_LRU) begin
                                age_q[in_set][hit_way] <= stamp_q;
                                stamp_q <= stamp_q + 1'b1;
                            end else if (mode == REPL_LFU && cur_age != '1) begin
                                age_q[in_set][hit_way] <= cur_age + 1'b1;
                            end
                            if (core_we) begin
                                if (wb_mode) dirty_q[in_set][hit_way] <= 1'b1;
                                st <= wb_mode ? ST_RESP : ST_WTHRU;
                            end else begin
                                rdata_r <= data_q[in_set][hit_way][in_off];
                                st      <= ST_RESP;
                            end
                        end else begin
                            miss_cnt <= miss_cnt + 1'b1;
                            if (core_we && !wb_mode) begin
                                st <= ST_WTHRU;
                            end else begin
                                way_r  <= vic_way;
                                beat_r <= '0;
                                valid_q[in_set][vic_way] <= 1'b0;
                                st <= (wb_mode && valid_q[in_set][vic_way] &&
                                       dirty_q[in_set][vic_way]) ? ST_EVICT : ST_FILL;
                            end
                        end
                    end
                end
                ST_EVICT: if (mem_ready) begin
                    beat_r <= beat_r + 1'b1;
                    if (last_beat) begin
                        beat_r <= '0;
                        st     <= ST_FILL;
                    end
                end
                ST_FILL: if (mem_ready) begin
                    beat_r <= beat_r + 1'b1;
                    if (last_beat) begin
                        valid_q[set_r][way_r] <= 1'b1;
                        dirty_q[set_r][way_r] <= 1'b0;
                        tag_q[set_r][way_r]   <= tag_r;
                        age_q[set_r][way_r]   <= '0;
                        replay_r <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                ST_WTHRU: if (mem_ready) st <= ST_RESP;
                ST_RESP:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cache_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level properties of the cache controller, attached by bind.
// Assumes: reset is synchronous and active low.
module cache_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              core_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [CNT_W-1:0]  hit_cnt,
    input logic [CNT_W-1:0]  miss_cnt
);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);

    // R9
    one_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((hit_cnt != $past(hit_cnt)) && (miss_cnt != $past(miss_cnt))));

    // R9
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt != $past(hit_cnt)) |-> (hit_cnt == $past(hit_cnt) + 1'b1));

    // R9
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt != $past(miss_cnt)) |-> (miss_cnt == $past(miss_cnt) + 1'b1));

    // R10
    inv_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !mem_req && !core_done) |-> ##2 $stable(hit_cnt));
endmodule

bind set_assoc_cache cache_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .core_done(core_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
);

// File: tb/set_assoc_cache_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed policy scenarios plus swept random traffic
// over every policy pairing, against a flat memory and a core-view model.
module set_assoc_cache_bench;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int MW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    repl_mode = 2'd1;
    logic          wb_mode = 1'b1;
    logic          inv_all = 1'b0;
    logic          core_req = 1'b0;
    logic          core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_done;
    logic [DW-1:0] core_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ready;
    logic [15:0]   hit_cnt, miss_cnt;

    logic [DW-1:0] mem_arr [MW];
    logic [DW-1:0] ref_mem [MW];
    int rd_beats, wr_beats, rd_mark, wr_mark;
    logic [AW-1:0] rd_first, rd_last, wr_first;
    int tests = 0, fails = 0;
    int d_hit, d_miss, d_rd, d_wr;
    logic [DW-1:0] rv;

    always #2.5 clk = ~clk;

    set_assoc_cache u_set_assoc_cache (
        .clk(clk), .rst_n(rst_n), .repl_mode(repl_mode), .wb_mode(wb_mode),
        .inv_all(inv_all), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
        .core_rdata(core_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    assign mem_rdata = mem_arr[mem_addr];

    // Memory model: one wait cycle per beat, beat logging.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            rd_beats  <= 0;
            wr_beats  <= 0;
            for (int i = 0; i < MW; i++) mem_arr[i] <= 32'h1000_0000 + 32'(i * 7);
        end else begin
            mem_ready <= mem_req && !mem_ready;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem_arr[mem_addr] <= mem_wdata;
                    if (wr_beats == wr_mark) wr_first <= mem_addr;
                    wr_beats <= wr_beats + 1;
                end else begin
                    if (rd_beats == rd_mark) rd_first <= mem_addr;
                    rd_last  <= mem_addr;
                    rd_beats <= rd_beats + 1;
                end
            end
        end
    end

    function automatic int A(int tag, int set, int off);
        return (tag << 4) | (set << 2) | off;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sync_ref();
        for (int i = 0; i < MW; i++) ref_mem[i] = mem_arr[i];
    endtask

    // One core access; optionally with a same-cycle invalidate.
    task automatic access(bit we, int a, logic [DW-1:0] wd, bit with_inv,
                          output logic [DW-1:0] rd);
        int h0, m0, guard;
        @(negedge clk);
        h0 = hit_cnt; m0 = miss_cnt;
        rd_mark = rd_beats; wr_mark = wr_beats;
        core_req = 1'b1; core_we = we; core_addr = AW'(a); core_wdata = wd;
        inv_all = with_inv;
        guard = 0;
        forever begin
            @(negedge clk);
            inv_all = 1'b0;
            guard++;
            if (core_done || guard > 300) break;
        end
        if (guard > 300) chk(0, "watchdog access", guard, 0);
        core_req = 1'b0;
        rd = core_rdata;
        d_hit = int'(hit_cnt) - h0; d_miss = int'(miss_cnt) - m0;
        d_rd = rd_beats - rd_mark;  d_wr = wr_beats - wr_mark;
        if (with_inv) sync_ref();
        if (we) ref_mem[a] = wd;
    endtask

    task automatic do_inv();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        sync_ref();
    endtask

    // Swept pseudo-random traffic for one policy pairing.
    task automatic sweep(bit wb, logic [1:0] rm);
        logic [31:0] x;
        wb_mode = wb; repl_mode = rm;
        do_inv();
        x = 32'h1234_5678 ^ {30'd0, rm} ^ {31'd0, wb};
        for (int n = 0; n < 300; n++) begin
            int a;
            bit we;
            x  = x * 32'd1103515245 + 32'd12345;
            a  = A(8 + int'(x[17:16]), int'(x[21:20]), int'(x[25:24]));
            we = (x[29:28] == 2'b00);
            access(we, a, x ^ 32'hA5A5_0000, 1'b0, rv);
            if (!we) chk(rv == ref_mem[a], "R2 sweep read data", rv, ref_mem[a]);
            chk(d_hit + d_miss == 1, "R9 one count per access", d_hit + d_miss, 1);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        sync_ref();
        @(negedge clk);
        // Reset state
        chk(hit_cnt == 0 && miss_cnt == 0, "R9 reset counters", hit_cnt, 0);
        chk(!mem_req && !core_done, "R11 reset idle port", mem_req, 0);

        // LRU, write-back: first fill, addressing, hit
        access(0, A(1,0,0), 0, 0, rv);
        chk(rv == ref_mem[A(1,0,0)], "R1 fill data", rv, ref_mem[A(1,0,0)]);
        chk(d_rd == 4 && d_wr == 0, "R1 fill beats", d_rd, 4);
        chk(rd_first == AW'(A(1,0,0)) && rd_last == AW'(A(1,0,3)), "R1 fill order", rd_last, A(1,0,3));
        chk(d_miss == 1, "R9 miss count", d_miss, 1);
        access(0, A(1,0,2), 0, 0, rv);
        chk(d_hit == 1 && d_rd == 0, "R2 read hit no traffic", d_rd, 0);
        chk(rv == ref_mem[A(1,0,2)], "R2 hit data", rv, ref_mem[A(1,0,2)]);
        access(0, A(2,0,0), 0, 0, rv);
        chk(d_miss == 1, "R3 second tag miss", d_miss, 1);
        access(0, A(1,0,1), 0, 0, rv);
        chk(d_hit == 1, "R3 first way kept", d_hit, 1);
        access(0, A(2,0,1), 0, 0, rv);
        chk(d_hit == 1, "R3 free way filled", d_hit, 1);

        // LRU eviction
        access(0, A(3,0,0), 0, 0, rv);
        chk(d_miss == 1 && d_wr == 0, "R5 clean victim", d_wr, 0);
        access(0, A(2,0,0), 0, 0, rv);
        chk(d_hit == 1, "R5 recent way kept", d_hit, 1);
        access(0, A(1,0,0), 0, 0, rv);
        chk(d_miss == 1, "R5 oldest way evicted", d_miss, 1);

        // Write-back: silent hit, dirty write-back before fill
        access(1, A(2,0,3), 32'hDEAD_BEEF, 0, rv);
        chk(d_hit == 1 && d_wr == 0 && d_rd == 0, "R8 write hit silent", d_wr, 0);
        access(0, A(1,0,0), 0, 0, rv);
        access(0, A(4,0,0), 0, 0, rv);
        chk(d_wr == 4 && d_rd == 4, "R8 dirty victim beats", d_wr, 4);
        chk(wr_first == AW'(A(2,0,0)), "R1 write-back order", wr_first, A(2,0,0));
        chk(mem_arr[A(2,0,3)] == 32'hDEAD_BEEF, "R8 written back", mem_arr[A(2,0,3)], 32'hDEAD_BEEF);
        access(0, A(2,0,3), 0, 0, rv);
        chk(rv == 32'hDEAD_BEEF, "R8 refetch", rv, 32'hDEAD_BEEF);

        // Invalidate alone, then together with a request
        access(0, A(6,2,0), 0, 0, rv);
        access(0, A(6,2,0), 0, 0, rv);
        chk(d_hit == 1, "R10 resident before", d_hit, 1);
        begin
            int h, m;
            h = hit_cnt; m = miss_cnt;
            do_inv();
            chk(hit_cnt == 16'(h) && miss_cnt == 16'(m), "R10 counters kept", hit_cnt, h);
        end
        access(0, A(6,2,0), 0, 0, rv);
        chk(d_miss == 1 && d_rd == 4, "R10 miss after invalidate", d_miss, 1);
        access(0, A(6,2,0), 0, 0, rv);
        chk(d_hit == 1, "R10 resident again", d_hit, 1);
        access(0, A(6,2,0), 0, 1, rv);
        chk(d_miss == 1 && d_hit == 0 && d_rd == 4, "R10 invalidate wins same cycle", d_miss, 1);
        chk(rv == ref_mem[A(6,2,0)], "R10 data after combo", rv, ref_mem[A(6,2,0)]);

        // LFU: recency loses to frequency
        repl_mode = 2'd2;
        do_inv();
        access(0, A(1,0,0), 0, 0, rv);
        access(0, A(2,0,0), 0, 0, rv);
        for (int k = 0; k < 3; k++) access(0, A(2,0,1), 0, 0, rv);
        access(0, A(1,0,1), 0, 0, rv);
        access(0, A(3,0,0), 0, 0, rv);
        chk(d_miss == 1, "R6 new tag miss", d_miss, 1);
        access(0, A(2,0,0), 0, 0, rv);
        chk(d_hit == 1, "R6 frequent way kept", d_hit, 1);
        access(0, A(1,0,0), 0, 0, rv);
        chk(d_miss == 1, "R6 rare recent way evicted", d_miss, 1);

        // Random
        repl_mode = 2'd0;
        do_inv();
        access(0, A(1,1,0), 0, 0, rv);
        access(0, A(2,1,0), 0, 0, rv);
        access(0, A(3,1,0), 0, 0, rv);
        chk(d_miss == 1 && d_rd == 4, "R4 full set miss", d_rd, 4);
        access(0, A(3,1,2), 0, 0, rv);
        chk(d_hit == 1 && rv == ref_mem[A(3,1,2)], "R4 missed block resident", rv, ref_mem[A(3,1,2)]);
        for (int t = 4; t < 20; t++) begin
            access(0, A(t,2,1), 0, 0, rv);
            access(0, A(t,2,3), 0, 0, rv);
            chk(d_hit == 1 && rv == ref_mem[A(t,2,3)], "R4 each fill resident", d_hit, 1);
        end

        // Write-through
        wb_mode = 1'b0; repl_mode = 2'd1;
        do_inv();
        access(1, A(5,3,1), 32'h0BAD_F00D, 0, rv);
        chk(d_wr == 1 && d_rd == 0 && d_miss == 1, "R7 write miss one beat", d_wr, 1);
        chk(mem_arr[A(5,3,1)] == 32'h0BAD_F00D, "R7 memory updated", mem_arr[A(5,3,1)], 32'h0BAD_F00D);
        access(0, A(5,3,1), 0, 0, rv);
        chk(d_miss == 1 && rv == 32'h0BAD_F00D, "R7 no allocate", d_miss, 1);
        access(1, A(5,3,2), 32'h1357_2468, 0, rv);
        chk(d_hit == 1 && d_wr == 1, "R7 write hit goes through", d_wr, 1);
        chk(mem_arr[A(5,3,2)] == 32'h1357_2468, "R7 hit memory", mem_arr[A(5,3,2)], 32'h1357_2468);
        access(0, A(5,3,2), 0, 0, rv);
        chk(d_hit == 1 && d_rd == 0 && rv == 32'h1357_2468, "R7 cache updated", rv, 32'h1357_2468);

        // Sweep every pairing
        for (int w = 0; w < 2; w++)
            for (int r = 0; r < 3; r++)
                sweep(w[0], 2'(r));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule